// File: doc/BRIEF.md
# Platform-Level External Interrupt Controller

This block collects level-sensitive interrupt requests from up to 31 devices and routes them to the harts of a small multi-hart system. Every hart is served by two targets: a machine-mode context and a supervisor-mode context. Each context drives one external-interrupt line to its hart. Software programs the controller over a simple 32-bit register bus, which answers every request one cycle later and flags any access it rejects.

Software sets a priority for each source, an enable bit per source and per context, and a threshold per context. When a source becomes pending in a context, its priority at that moment is stored with it. Software then claims the best pending source by reading the context's claim register. A claimed source stays hidden from that context until software writes its ID back as a completion. A rising or falling level is applied only to the lowest-numbered context that has the source enabled.

Top module: `irq_ctrl`

## Requirements
- R1: Only word accesses (size code 2) to word-aligned addresses are accepted. Every request gets a response one cycle later. A rejected access sets the error flag, returns zero data and changes no state.
- R2: The priority of source ID sits at byte offset 4*ID and holds 4 bits; bits written above these are dropped. Reading or writing ID 0, or any ID of 32 or more, is an error.
- R3: The enable bank of context c starts at 0x2000 + 0x80*c and holds one bit per source. Bit k of word 0 belongs to source k. Bit 0 always reads as zero. Words beyond the implemented sources, and contexts of 4 or more, give an error.
- R4: The control block of context c starts at 0x200000 + 0x1000*c. Offset 0 is a 4-bit threshold and offset 4 is claim/complete. Any other offset in the block gives an error.
- R5: A source becomes pending in a context when its level rises while it is enabled there. The source's priority at that moment is stored with it, and later priority writes do not change the stored value.
- R6: Setting an enable bit while the source's level is high makes the source pending in that context, using the current priority.
- R7: A falling level, or clearing the enable bit, removes the source's pending and claimed state in the affected context.
- R8: A level change is applied only to the lowest-numbered context that has the source enabled.
- R9: A claim read returns the unclaimed pending source with the highest stored priority, choosing the lowest ID on a tie, or 0 if there is none. The returned source is marked claimed and is not offered again until it is completed.
- R10: Writing an ID to claim/complete clears its claimed mark only when the ID is below 32 and is enabled in that context. Any other value has no effect.
- R11: A context's line is high exactly when its best candidate's stored priority is strictly greater than the context's threshold. The line follows any state change in the next cycle.
- R12: Context 2h drives meip_o[h], the machine line of hart h, and context 2h+1 drives seip_o[h], the supervisor line of hart h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size code; 2 = 32-bit |
| addr_i | input | AW (24) | Byte address relative to the block base |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Access rejected |
| src_i | input | N_SRC (31) | Source levels; bit k is source ID k+1 |
| meip_o | output | N_HARTS (2) | Machine external interrupt, one per hart |
| seip_o | output | N_HARTS (2) | Supervisor external interrupt, one per hart |

## Verification
A corrupted stored priority or pending bit appears on the interrupt line in the cycle after the update. It also appears in the ID returned by the next claim read, so every scenario checks both the line and the claim data. A stale claimed bit is hidden until software tries to re-offer the source. The bench therefore completes or re-enables a source and then checks that the line comes back and that the same ID is claimed again. Routing faults appear as a line rising on the wrong hart or context, which is checked against every other line in the same cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned EN_BASE      = 32'h0000_2000;
  localparam int unsigned EN_STRIDE_LG = 7;
  localparam int unsigned CTL_BASE     = 32'h0020_0000;
  localparam int unsigned CTL_STRIDE_LG = 12;
  localparam logic [1:0]  SZ_WORD      = 2'd2;

  typedef enum logic [2:0] {
    K_NONE,
    K_PRIO,
    K_EN,
    K_THR,
    K_CLM
  } reg_kind_e;
endpackage

// File: rtl/irq_ctrl_dec.sv
module irq_ctrl_dec
  import irq_ctrl_pkg::*;
#(
  parameter int AW      = 24,
  parameter int N_CTX   = 4,
  parameter int NUM_IDS = 32,
  parameter int N_WORDS = 1,
  parameter int CW      = 2,
  parameter int NIW     = 5,
  parameter int WW      = 1
) (
  input  logic          req_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  output reg_kind_e     kind_o,
  output logic [CW-1:0] ctx_o,
  output logic [NIW-1:0] id_o,
  output logic [WW-1:0] word_o
);
  logic [AW-1:0] off_en, off_ctl, ctx_w;
  logic [AW-3:0] pid;

  always_comb begin
    kind_o  = K_NONE;
    ctx_w   = '0;
    off_en  = addr_i - AW'(EN_BASE);
    off_ctl = addr_i - AW'(CTL_BASE);
    pid     = addr_i[AW-1:2];
    word_o  = WW'(off_en >> 2);
    if (addr_i < AW'(EN_BASE)) begin
      if (pid != '0 && pid < (AW-2)'(NUM_IDS)) kind_o = K_PRIO;
    end else if (addr_i < AW'(CTL_BASE)) begin
      ctx_w = off_en >> EN_STRIDE_LG;
      if (ctx_w < AW'(N_CTX) && off_en[EN_STRIDE_LG-1:2] < (EN_STRIDE_LG-2)'(N_WORDS))
        kind_o = K_EN;
    end else begin
      ctx_w = off_ctl >> CTL_STRIDE_LG;
      if (ctx_w < AW'(N_CTX)) begin
        if (off_ctl[CTL_STRIDE_LG-1:0] == '0) kind_o = K_THR;
        else if (off_ctl[CTL_STRIDE_LG-1:0] == CTL_STRIDE_LG'(4)) kind_o = K_CLM;
      end
    end
    if (!req_i || size_i != SZ_WORD || addr_i[1:0] != 2'b00) kind_o = K_NONE;
    ctx_o = CW'(ctx_w);
    id_o  = NIW'(pid);
  end
endmodule

// File: rtl/irq_ctrl_route.sv
// Maps each source level change to the lowest-numbered context enabling it.
module irq_ctrl_route #(
  parameter int N_CTX   = 4,
  parameter int NUM_IDS = 32
) (
  input  logic [N_CTX-1:0][NUM_IDS-1:0] en_i,
  input  logic [NUM_IDS-1:0]            lvl_new_i,
  input  logic [NUM_IDS-1:0]            lvl_old_i,
  output logic [N_CTX-1:0][NUM_IDS-1:0] rise_o,
  output logic [N_CTX-1:0][NUM_IDS-1:0] fall_o
);
  logic hit;

  always_comb begin
    rise_o = '0;
    fall_o = '0;
    hit    = 1'b0;
    for (int i = 0; i < NUM_IDS; i++) begin
      hit = 1'b0;
      for (int c = 0; c < N_CTX; c++) begin
        if (!hit && en_i[c][i]) begin
          hit = 1'b1;
          rise_o[c][i] = lvl_new_i[i] && !lvl_old_i[i];
          fall_o[c][i] = !lvl_new_i[i] && lvl_old_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_pick.sv
// Best-candidate search: highest stored priority, lowest ID on tie.
module irq_ctrl_pick #(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 4,
  parameter int NIW     = 5
) (
  input  logic [NUM_IDS-1:0]             cand_i,
  input  logic [NUM_IDS-1:0][PRIO_W-1:0] cap_i,
  output logic                           found_o,
  output logic [NIW-1:0]                 id_o,
  output logic [PRIO_W-1:0]              prio_o
);
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (cand_i[i] && (!found_o || cap_i[i] > prio_o)) begin
        found_o = 1'b1;
        id_o    = NIW'(i);
        prio_o  = cap_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_HARTS = 2,
  parameter int N_SRC   = 31,
  parameter int PRIO_W  = 4,
  parameter int AW      = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rdata_o,
  output logic               err_o,
  input  logic [N_SRC-1:0]   src_i,
  output logic [N_HARTS-1:0] meip_o,
  output logic [N_HARTS-1:0] seip_o
);
  localparam int N_CTX   = 2 * N_HARTS;
  localparam int NUM_IDS = N_SRC + 1;
  localparam int N_WORDS = (NUM_IDS + 31) / 32;
  localparam int IDB     = N_WORDS * 32;
  localparam int IDW     = $clog2(IDB);
  localparam int NIW     = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
  localparam int CW      = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam int WW      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [NUM_IDS-1:0][PRIO_W-1:0]            prio_q, prio_d;
  logic [N_CTX-1:0][IDB-1:0]                 en_q, en_d;
  logic [N_CTX-1:0][NUM_IDS-1:0]             en_lo;
  logic [N_CTX-1:0][NUM_IDS-1:0]             pend_q, pend_d, clm_q, clm_d, cand;
  logic [N_CTX-1:0][NUM_IDS-1:0][PRIO_W-1:0] cap_q, cap_d;
  logic [N_CTX-1:0][PRIO_W-1:0]              thr_q, thr_d;
  logic [NUM_IDS-1:0]                        lvl_q, lvl_now;
  logic [N_CTX-1:0][NUM_IDS-1:0]             rise, fall;
  logic [N_CTX-1:0]                          found, irq;
  logic [N_CTX-1:0][NIW-1:0]                 best_id;
  logic [N_CTX-1:0][PRIO_W-1:0]              best_prio;

  reg_kind_e      kind;
  logic [CW-1:0]  dctx;
  logic [NIW-1:0] did;
  logic [WW-1:0]  dword;
  logic [31:0]    rd_d, rdata_q;
  logic           rsp_q, err_q;
  int             eid;

  assign lvl_now = {src_i, 1'b0};

  irq_ctrl_dec #(
    .AW(AW), .N_CTX(N_CTX), .NUM_IDS(NUM_IDS), .N_WORDS(N_WORDS),
    .CW(CW), .NIW(NIW), .WW(WW)
  ) u_dec (
    .req_i (req_i),
    .size_i(size_i),
    .addr_i(addr_i),
    .kind_o(kind),
    .ctx_o (dctx),
    .id_o  (did),
    .word_o(dword)
  );

  always_comb begin
    for (int c = 0; c < N_CTX; c++) en_lo[c] = en_q[c][NUM_IDS-1:0];
  end

  irq_ctrl_route #(.N_CTX(N_CTX), .NUM_IDS(NUM_IDS)) u_route (
    .en_i     (en_lo),
    .lvl_new_i(lvl_now),
    .lvl_old_i(lvl_q),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    assign cand[c] = pend_q[c] & ~clm_q[c];
    irq_ctrl_pick #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .NIW(NIW)) u_pick (
      .cand_i (cand[c]),
      .cap_i  (cap_q[c]),
      .found_o(found[c]),
      .id_o   (best_id[c]),
      .prio_o (best_prio[c])
    );
    assign irq[c] = found[c] && (best_prio[c] > thr_q[c]);
  end

  for (genvar h = 0; h < N_HARTS; h++) begin : g_hart
    assign meip_o[h] = irq[2*h];
    assign seip_o[h] = irq[2*h+1];
  end

  // Next state: level events first, then the bus access overrides.
  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    pend_d = pend_q;
    clm_d  = clm_q;
    cap_d  = cap_q;
    thr_d  = thr_q;
    eid    = 0;
    for (int c = 0; c < N_CTX; c++) begin
      for (int i = 0; i < NUM_IDS; i++) begin
        if (rise[c][i]) begin
          pend_d[c][i] = 1'b1;
          cap_d[c][i]  = prio_q[i];
        end
        if (fall[c][i]) begin
          pend_d[c][i] = 1'b0;
          cap_d[c][i]  = '0;
          clm_d[c][i]  = 1'b0;
        end
      end
    end
    unique case (kind)
      K_PRIO: if (we_i) prio_d[did] = wdata_i[PRIO_W-1:0];
      K_EN: if (we_i) begin
        for (int b = 0; b < 32; b++) begin
          eid = int'(dword) * 32 + b;
          if (eid < NUM_IDS && eid != 0) begin
            en_d[dctx][IDW'(eid)] = wdata_i[b];
            if (wdata_i[b] && !en_q[dctx][IDW'(eid)] && lvl_now[NIW'(eid)]) begin
              pend_d[dctx][NIW'(eid)] = 1'b1;
              cap_d[dctx][NIW'(eid)]  = prio_q[NIW'(eid)];
            end else if (!wdata_i[b] && en_q[dctx][IDW'(eid)]) begin
              pend_d[dctx][NIW'(eid)] = 1'b0;
              cap_d[dctx][NIW'(eid)]  = '0;
              clm_d[dctx][NIW'(eid)]  = 1'b0;
            end
          end
        end
      end
      K_THR: if (we_i) thr_d[dctx] = wdata_i[PRIO_W-1:0];
      K_CLM: begin
        if (we_i) begin
          if (wdata_i < 32'(NUM_IDS) && en_q[dctx][IDW'(wdata_i)])
            clm_d[dctx][NIW'(wdata_i)] = 1'b0;
        end else if (found[dctx] && pend_d[dctx][best_id[dctx]]) begin
          clm_d[dctx][best_id[dctx]] = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    rd_d = '0;
    if (!we_i) begin
      unique case (kind)
        K_PRIO:  rd_d = 32'(prio_q[did]);
        K_EN:    rd_d = en_q[dctx][int'(dword)*32 +: 32];
        K_THR:   rd_d = 32'(thr_q[dctx]);
        K_CLM:   rd_d = 32'(best_id[dctx]);
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      clm_q   <= '0;
      cap_q   <= '0;
      thr_q   <= '0;
      lvl_q   <= '0;
      rsp_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      prio_q  <= prio_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
      clm_q   <= clm_d;
      cap_q   <= cap_d;
      thr_q   <= thr_d;
      lvl_q   <= lvl_now;
      rsp_q   <= req_i;
      err_q   <= req_i && (kind == K_NONE);
      rdata_q <= rd_d;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_HARTS = 2,
  parameter int N_CTX   = 4,
  parameter int NUM_IDS = 32,
  parameter int IDB     = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_i,
  input logic [1:0]               size_i,
  input logic                     rsp_valid_o,
  input logic                     err_o,
  input logic [N_HARTS-1:0]       meip_o,
  input logic [N_HARTS-1:0]       seip_o,
  input logic [N_CTX*IDB-1:0]     en_i,
  input logic [N_CTX*NUM_IDS-1:0] pend_i,
  input logic [N_CTX*NUM_IDS-1:0] clm_i
);
  logic [N_CTX-1:0] irq;
  always_comb begin
    for (int h = 0; h < N_HARTS; h++) begin
      irq[2*h]   = meip_o[h];
      irq[2*h+1] = seip_o[h];
    end
  end

  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o) else $error("R1 missing response");
  a_r1_no_idle_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o) else $error("R1 response without request");
  a_r1_size_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != 2'd2) |=> err_o) else $error("R1 bad size accepted");
  a_r9_claimed_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clm_i & ~pend_i) == '0) else $error("R9 claimed source not pending");

  for (genvar c = 0; c < N_CTX; c++) begin : g_c
    a_r11_line_has_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq[c] |-> (|(pend_i[c*NUM_IDS +: NUM_IDS] & ~clm_i[c*NUM_IDS +: NUM_IDS])))
      else $error("R11 line high without candidate");
    a_r3_bit0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[c*IDB]) else $error("R3 enable bit 0 set");
  end
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .N_HARTS(N_HARTS), .N_CTX(N_CTX), .NUM_IDS(NUM_IDS), .IDB(IDB)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .size_i     (size_i),
  .rsp_valid_o(rsp_valid_o),
  .err_o      (err_o),
  .meip_o     (meip_o),
  .seip_o     (seip_o),
  .en_i       (en_q),
  .pend_i     (pend_q),
  .clm_i      (clm_q)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  sz = 2'd2;
  logic [23:0] addr = '0;
  logic [31:0] wd = '0;
  logic [30:0] src = '0;
  logic        rsp_valid, err;
  logic [31:0] rdata;
  logic [1:0]  meip, seip;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(sz),
    .addr_i(addr), .wdata_i(wd), .rsp_valid_o(rsp_valid), .rdata_o(rdata),
    .err_o(err), .src_i(src), .meip_o(meip), .seip_o(seip)
  );

  function automatic logic [23:0] pa(input int id); return 24'(4 * id); endfunction
  function automatic logic [23:0] ea(input int c); return 24'h2000 + 24'(c * 128); endfunction
  function automatic logic [23:0] ta(input int c); return 24'h200000 + 24'(c * 4096); endfunction
  function automatic logic [23:0] ca(input int c); return ta(c) + 24'd4; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [23:0] a, input logic [31:0] d,
                     input logic [1:0] s, output logic [31:0] r, output logic e);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wd = d; sz = s;
    @(negedge clk);
    r = rdata; e = err;
    req = 1'b0; we = 1'b0; sz = 2'd2;
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    acc(1'b1, a, d, 2'd2, r, e);
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] r);
    logic e;
    acc(1'b0, a, 32'd0, 2'd2, r, e);
  endtask

  task automatic set_src(input logic [30:0] mask, input logic v);
    @(negedge clk);
    src = v ? (src | mask) : (src & ~mask);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1 reset rsp", 32'(rsp_valid), 0);
    chk("R12 reset lines", 32'({seip, meip}), 0);
    rd(ta(0), r);  chk("R4 reset threshold", r, 0);
    rd(pa(1), r);  chk("R2 reset priority", r, 0);
  endtask

  task automatic t_prio_regs;
    logic [31:0] r; logic e;
    wr(pa(3), 32'h1F);
    rd(pa(3), r); chk("R2 priority truncated", r, 32'hF);
    acc(1'b0, pa(0), 0, 2'd2, r, e);  chk("R2 id0 error", 32'(e), 1);
    acc(1'b0, pa(32), 0, 2'd2, r, e); chk("R2 id32 error", 32'(e), 1);
    acc(1'b0, pa(3), 0, 2'd1, r, e);  chk("R1 halfword error", 32'(e), 1);
    chk("R1 error data zero", r, 0);
    acc(1'b1, pa(3), 0, 2'd0, r, e);  chk("R1 byte write error", 32'(e), 1);
    rd(pa(3), r); chk("R1 rejected write ignored", r, 32'hF);
    acc(1'b0, 24'h00D, 0, 2'd2, r, e); chk("R1 misaligned error", 32'(e), 1);
  endtask

  task automatic t_enable_regs;
    logic [31:0] r; logic e;
    wr(ea(0), 32'hFFFF_FFFF);
    rd(ea(0), r); chk("R3 bit0 reads zero", r, 32'hFFFF_FFFE);
    acc(1'b0, ea(4), 0, 2'd2, r, e); chk("R3 ctx4 error", 32'(e), 1);
    acc(1'b0, ea(0) + 24'd4, 0, 2'd2, r, e); chk("R3 word1 error", 32'(e), 1);
    wr(ea(0), 0);
  endtask

  task automatic t_ctl_regs;
    logic [31:0] r; logic e;
    wr(ta(1), 32'h13);
    rd(ta(1), r); chk("R4 threshold truncated", r, 3);
    acc(1'b0, ta(1) + 24'd8, 0, 2'd2, r, e); chk("R4 offset8 error", 32'(e), 1);
    acc(1'b0, ta(4), 0, 2'd2, r, e); chk("R4 ctx4 error", 32'(e), 1);
    wr(ta(1), 0);
  endtask

  task automatic t_capture_claim;
    logic [31:0] r;
    wr(pa(5), 3); wr(ea(0), 32'h20); wr(ta(0), 0);
    set_src(31'(1) << 4, 1'b1);
    chk("R5 rise sets line", 32'(meip[0]), 1);
    wr(pa(5), 1); wr(ta(0), 2);
    chk("R5 captured priority kept", 32'(meip[0]), 1);
    wr(ta(0), 3);
    chk("R11 equal threshold masks", 32'(meip[0]), 0);
    wr(ta(0), 2);
    rd(ca(0), r); chk("R9 claim id", r, 5);
    chk("R9 claimed hidden", 32'(meip[0]), 0);
    rd(ca(0), r); chk("R9 empty claim", r, 0);
    wr(ca(0), 37);
    chk("R10 out-of-range complete ignored", 32'(meip[0]), 0);
    wr(ca(0), 5);
    chk("R10 complete re-offers", 32'(meip[0]), 1);
    set_src(31'(1) << 4, 1'b0);
    chk("R7 fall clears line", 32'(meip[0]), 0);
    rd(ca(0), r); chk("R7 fall clears pending", r, 0);
    wr(ea(0), 0); wr(ta(0), 0);
  endtask

  task automatic t_enable_while_high;
    logic [31:0] r;
    wr(pa(7), 2);
    set_src(31'(1) << 6, 1'b1);
    chk("R6 no enable no line", 32'(seip[0]), 0);
    wr(ea(1), 32'h80);
    chk("R6 enable while high", 32'(seip[0]), 1);
    rd(ca(1), r); chk("R6 claim id", r, 7);
    wr(ea(1), 0); wr(ea(1), 32'h80);
    chk("R7 disable clears claimed", 32'(seip[0]), 1);
    rd(ca(1), r); chk("R7 reclaim after disable", r, 7);
    wr(ea(1), 0);
    rd(ca(1), r); chk("R7 disable clears pending", r, 0);
    set_src(31'(1) << 6, 1'b0);
  endtask

  task automatic t_lowest_ctx;
    logic [31:0] r;
    wr(pa(9), 4); wr(ea(1), 32'h200); wr(ea(2), 32'h200);
    set_src(31'(1) << 8, 1'b1);
    chk("R8 lowest context line", 32'(seip[0]), 1);
    chk("R8 higher context idle", 32'(meip[1]), 0);
    rd(ca(2), r); chk("R8 higher context empty", r, 0);
    set_src(31'(1) << 8, 1'b0);
    wr(ea(1), 0); wr(ea(2), 0);
  endtask

  task automatic t_order;
    logic [31:0] r;
    wr(pa(2), 5); wr(pa(3), 7); wr(pa(4), 7); wr(ea(0), 32'h1C);
    set_src(31'h0E, 1'b1);
    rd(ca(0), r); chk("R9 highest tie lowest", r, 3);
    rd(ca(0), r); chk("R9 tie second", r, 4);
    rd(ca(0), r); chk("R9 lowest priority", r, 2);
    rd(ca(0), r); chk("R9 all claimed", r, 0);
    set_src(31'h0E, 1'b0);
    wr(ea(0), 0);
  endtask

  task automatic t_hart_map;
    wr(pa(10), 1); wr(ea(3), 32'h400);
    set_src(31'(1) << 9, 1'b1);
    chk("R12 ctx3 drives hart1 supervisor", 32'({seip, meip}), 32'b1000);
    set_src(31'(1) << 9, 1'b0);
    chk("R12 line drops", 32'({seip, meip}), 0);
    wr(ea(3), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prio_regs();
    t_enable_regs();
    t_ctl_regs();
    t_capture_claim();
    t_enable_while_high();
    t_lowest_ctx();
    t_order();
    t_hart_map();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule